// File: doc/BRIEF.md
# Store-Queue Index Tag Rewriter

This unit keeps in-flight loads attached to the store they are predicted to forward from when the stores of a control-dependent region are squashed and replaced. A store-PC table maps each store PC to the store-queue slot that store holds. A forwarding table maps a load PC to a store PC. When a load is dispatched, the two lookups are chained. The resulting store-queue slot becomes the load's memory tag, which it later uses to read the store queue. A load with no forwarding prediction, or whose predicted store currently has no valid slot, gets a null tag.

At the convergence point a snapshot of the store-PC table is taken. The wrong-path stores are then removed and the correct-path stores written, and a repair is requested. The unit walks only the store-PC entries that differ between the snapshot and the live table, one per cycle. For each such entry it broadcasts an old-slot to new-slot replacement to the pending loads. Every load whose tag is replaced is flagged for re-dispatch. While the walk runs, load issue is stalled. Store-queue slots for the predicted region are reserved by the surrounding core, so stores past convergence keep their slots and only a few entries differ.

Top module: `store_tag_rewriter`

## Requirements
- R1: After reset no load is pending, `walk_busy` is 0 and `redisp_mask` is all zero; an issue request then gives `iss_valid` 0.
- R2: A dispatched load whose load PC has a valid forwarding entry pointing at a store PC with a valid slot carries that slot as its tag, reported with `iss_null` 0 when it issues.
- R3: A load without a valid forwarding entry, or whose predicted store PC has no valid slot, carries a null tag (`iss_null` 1). A null tag is never rewritten or flagged by a repair.
- R4: `repair_start` accepted while idle makes `walk_busy` 1 from the next cycle, for max(1, N) cycles, where N is the number of store-PC entries whose valid bit or slot differs from the snapshot taken by `ckpt_take`.
- R5: During the walk, each pending non-null load whose tag equals the snapshot slot of a differing, snapshot-valid entry takes the live slot of that entry. It becomes null if the live entry is invalid. In both cases it is flagged for re-dispatch. No flag is raised outside a walk.
- R6: A load is rewritten at most once per walk. Entries are walked from the lowest store PC upward, so if entry 1 moves from slot 3 to 5 and entry 2 from slot 5 to 7, a load that held 3 ends with 5.
- R7: A load whose tag matches no differing entry keeps its tag and is not flagged.
- R8: While `walk_busy` is 1, issue requests are refused (`iss_valid` 0) and the load stays pending.
- R9: Store-PC table writes presented while `walk_busy` is 1 are dropped.
- R10: Issuing a load frees its slot and clears its re-dispatch flag in `redisp_mask`; dispatching into a slot clears the flag as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_wr_en | input | 1 | Write the store-PC table |
| st_wr_pc | input | ST_PC_W | Store PC index written |
| st_wr_valid | input | 1 | 1 maps the PC to a slot, 0 removes the mapping |
| st_wr_sqi | input | SQ_W | Store-queue slot written |
| fp_wr_en | input | 1 | Write the forwarding table |
| fp_wr_ldpc | input | LD_PC_W | Load PC index written |
| fp_wr_valid | input | 1 | 1 sets a prediction, 0 clears it |
| fp_wr_stpc | input | ST_PC_W | Predicted store PC |
| ckpt_take | input | 1 | Snapshot the store-PC table (value before a same-cycle write) |
| repair_start | input | 1 | Begin the rewrite walk |
| disp_en | input | 1 | Dispatch a load into a slot |
| disp_slot | input | SLOT_W | Load slot written |
| disp_ldpc | input | LD_PC_W | PC of the dispatched load |
| iss_en | input | 1 | Issue request for a load slot |
| iss_slot | input | SLOT_W | Load slot requested |
| walk_busy | output | 1 | Rewrite walk in progress |
| iss_valid | output | 1 | Issue accepted this cycle |
| iss_tag | output | SQ_W | Store-queue slot tag of the issuing load |
| iss_null | output | 1 | Issuing load has a null tag |
| iss_redisp | output | 1 | Issuing load was flagged for re-dispatch |
| redisp_mask | output | LQ_N | Per-slot re-dispatch flags |

## Verification
The hardest case to reach is a chain of moves, where one entry's new slot is another entry's old slot. A load must then be rewritten only by the first entry and left alone by the second. A directed case builds exactly that chain, with a removal and an unchanged entry beside it. Random episodes draw slots from a small range, so such chains and shared slots arise often. Each random episode dispatches into every load slot, changes a few entries after the snapshot, repairs, and then issues every slot. During each walk the bench keeps requesting issue and writing the store-PC table, to show that both are held off.

// File: rtl/store_tag_rewriter.sv
module store_tag_rewriter #(
  parameter int ST_PC_W = 4,
  parameter int LD_PC_W = 4,
  parameter int SQ_W    = 5,
  parameter int LQ_N    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_wr_en,
  input  logic [ST_PC_W-1:0] st_wr_pc,
  input  logic               st_wr_valid,
  input  logic [SQ_W-1:0]    st_wr_sqi,
  input  logic               fp_wr_en,
  input  logic [LD_PC_W-1:0] fp_wr_ldpc,
  input  logic               fp_wr_valid,
  input  logic [ST_PC_W-1:0] fp_wr_stpc,
  input  logic               ckpt_take,
  input  logic               repair_start,
  input  logic               disp_en,
  input  logic [$clog2(LQ_N)-1:0] disp_slot,
  input  logic [LD_PC_W-1:0] disp_ldpc,
  input  logic               iss_en,
  input  logic [$clog2(LQ_N)-1:0] iss_slot,
  output logic               walk_busy,
  output logic               iss_valid,
  output logic [SQ_W-1:0]    iss_tag,
  output logic               iss_null,
  output logic               iss_redisp,
  output logic [LQ_N-1:0]    redisp_mask
);
  localparam int ST_N   = 1 << ST_PC_W;
  localparam int LD_N   = 1 << LD_PC_W;
  localparam int SLOT_W = $clog2(LQ_N);

  logic [ST_N-1:0]    cur_v, ck_v;
  logic [SQ_W-1:0]    cur_q [ST_N];
  logic [SQ_W-1:0]    ck_q  [ST_N];
  logic [LD_N-1:0]    fp_v;
  logic [ST_PC_W-1:0] fp_s  [LD_N];

  logic [LQ_N-1:0]    ld_v, ld_null, ld_rd, ld_done;
  logic [SQ_W-1:0]    ld_tag [LQ_N];

  logic               walk_on;
  logic [ST_N-1:0]    diff;
  logic [ST_PC_W-1:0] sel;
  logic               step, more;

  genvar gi;
  generate
    for (gi = 0; gi < ST_N; gi++) begin : g_diff
      assign diff[gi] = (cur_v[gi] != ck_v[gi]) ||
                        (cur_v[gi] && (cur_q[gi] != ck_q[gi]));
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = ST_N - 1; i >= 0; i--)
      if (diff[i]) sel = ST_PC_W'(i);
  end

  assign step = walk_on && (diff != '0);
  assign more = (diff & ~(ST_N'(1) << sel)) != '0;

  logic               old_v, new_v;
  logic [SQ_W-1:0]    old_q, new_q;
  assign old_v = ck_v[sel];
  assign old_q = ck_q[sel];
  assign new_v = cur_v[sel];
  assign new_q = cur_q[sel];

  logic [ST_PC_W-1:0] d_st;
  logic               d_null;
  logic [SQ_W-1:0]    d_tag;
  assign d_st   = fp_s[disp_ldpc];
  assign d_null = !fp_v[disp_ldpc] || !cur_v[d_st];
  assign d_tag  = d_null ? '0 : cur_q[d_st];

  logic iss_fire, rep_go;
  assign iss_fire = iss_en && !walk_on && ld_v[iss_slot];
  assign rep_go   = repair_start && !walk_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v   <= '0;
      ck_v    <= '0;
      walk_on <= 1'b0;
      for (int i = 0; i < ST_N; i++) begin
        cur_q[i] <= '0;
        ck_q[i]  <= '0;
      end
    end else if (!walk_on) begin
      if (ckpt_take) begin
        ck_v <= cur_v;
        for (int i = 0; i < ST_N; i++) ck_q[i] <= cur_q[i];
      end
      if (st_wr_en) begin
        cur_v[st_wr_pc] <= st_wr_valid;
        cur_q[st_wr_pc] <= st_wr_sqi;
      end
      if (repair_start) walk_on <= 1'b1;
    end else begin
      if (step) begin
        ck_v[sel] <= new_v;
        ck_q[sel] <= new_q;
      end
      if (!more) walk_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_v <= '0;
      for (int i = 0; i < LD_N; i++) fp_s[i] <= '0;
    end else if (fp_wr_en) begin
      fp_v[fp_wr_ldpc] <= fp_wr_valid;
      fp_s[fp_wr_ldpc] <= fp_wr_stpc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_v    <= '0;
      ld_null <= '0;
      ld_rd   <= '0;
      ld_done <= '0;
      for (int s = 0; s < LQ_N; s++) ld_tag[s] <= '0;
    end else begin
      for (int s = 0; s < LQ_N; s++) begin
        if (disp_en && disp_slot == SLOT_W'(s)) begin
          ld_v[s]    <= 1'b1;
          ld_null[s] <= d_null;
          ld_tag[s]  <= d_tag;
          ld_rd[s]   <= 1'b0;
          ld_done[s] <= 1'b1;
        end else begin
          if (iss_fire && iss_slot == SLOT_W'(s)) begin
            ld_v[s]  <= 1'b0;
            ld_rd[s] <= 1'b0;
          end
          if (step && ld_v[s] && !ld_null[s] && !ld_done[s] &&
              old_v && ld_tag[s] == old_q) begin
            ld_tag[s]  <= new_q;
            ld_null[s] <= !new_v;
            ld_rd[s]   <= 1'b1;
            ld_done[s] <= 1'b1;
          end
          if (rep_go) ld_done[s] <= 1'b0;
        end
      end
    end
  end

  assign walk_busy   = walk_on;
  assign iss_valid   = iss_fire;
  assign iss_tag     = ld_tag[iss_slot];
  assign iss_null    = ld_null[iss_slot];
  assign iss_redisp  = ld_rd[iss_slot];
  assign redisp_mask = ld_rd;
endmodule

// File: rtl/store_tag_rewriter_chk.sv
module store_tag_rewriter_chk #(
  parameter int LQ_N = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    repair_start,
  input logic                    iss_en,
  input logic [$clog2(LQ_N)-1:0] iss_slot,
  input logic                    walk_busy,
  input logic                    iss_valid,
  input logic [LQ_N-1:0]         redisp_mask
);
  assert_no_issue_in_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !iss_valid);

  assert_issue_only_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_en);

  assert_walk_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (repair_start && !walk_busy) |=> walk_busy);

  assert_no_flag_outside_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_busy |=> ((redisp_mask & ~$past(redisp_mask)) == '0));

  assert_issue_clears_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !redisp_mask[$past(iss_slot)]);
endmodule

bind store_tag_rewriter store_tag_rewriter_chk #(.LQ_N(LQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .repair_start(repair_start), .iss_en(iss_en),
  .iss_slot(iss_slot), .walk_busy(walk_busy), .iss_valid(iss_valid),
  .redisp_mask(redisp_mask)
);

// File: tb/store_tag_rewriter_tb.sv
module store_tag_rewriter_tb;
  localparam int CLK_P = 10;
  localparam int ST_N = 16, LD_N = 16, LQ_N = 8;

  logic clk = 0, rst_n = 0;
  logic st_wr_en = 0, st_wr_valid = 0, fp_wr_en = 0, fp_wr_valid = 0;
  logic [3:0] st_wr_pc = 0, fp_wr_ldpc = 0, fp_wr_stpc = 0, disp_ldpc = 0;
  logic [4:0] st_wr_sqi = 0;
  logic ckpt_take = 0, repair_start = 0, disp_en = 0, iss_en = 0;
  logic [2:0] disp_slot = 0, iss_slot = 0;
  logic walk_busy, iss_valid, iss_null, iss_redisp;
  logic [4:0] iss_tag;
  logic [LQ_N-1:0] redisp_mask;

  always #(CLK_P/2) clk = ~clk;

  store_tag_rewriter u_dut (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_pc(st_wr_pc),
    .st_wr_valid(st_wr_valid), .st_wr_sqi(st_wr_sqi), .fp_wr_en(fp_wr_en),
    .fp_wr_ldpc(fp_wr_ldpc), .fp_wr_valid(fp_wr_valid), .fp_wr_stpc(fp_wr_stpc),
    .ckpt_take(ckpt_take), .repair_start(repair_start), .disp_en(disp_en),
    .disp_slot(disp_slot), .disp_ldpc(disp_ldpc), .iss_en(iss_en),
    .iss_slot(iss_slot), .walk_busy(walk_busy), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .iss_null(iss_null), .iss_redisp(iss_redisp),
    .redisp_mask(redisp_mask));

  bit m_cv [ST_N]; int m_cq [ST_N];
  bit m_kv [ST_N]; int m_kq [ST_N];
  bit m_fv [LD_N]; int m_fs [LD_N];
  bit m_lv [LQ_N]; bit m_ln [LQ_N]; int m_lt [LQ_N]; bit m_lr [LQ_N];

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_store(input int pc, input bit v, input int q);
    st_wr_en = 1; st_wr_pc = 4'(pc); st_wr_valid = v; st_wr_sqi = 5'(q);
    @(negedge clk); st_wr_en = 0;
    m_cv[pc] = v; m_cq[pc] = q;
  endtask

  task automatic wr_fp(input int lp, input bit v, input int sp);
    fp_wr_en = 1; fp_wr_ldpc = 4'(lp); fp_wr_valid = v; fp_wr_stpc = 4'(sp);
    @(negedge clk); fp_wr_en = 0;
    m_fv[lp] = v; m_fs[lp] = sp;
  endtask

  task automatic take_ckpt();
    ckpt_take = 1; @(negedge clk); ckpt_take = 0;
    for (int i = 0; i < ST_N; i++) begin m_kv[i] = m_cv[i]; m_kq[i] = m_cq[i]; end
  endtask

  task automatic dispatch(input int s, input int lp);
    disp_en = 1; disp_slot = 3'(s); disp_ldpc = 4'(lp);
    @(negedge clk); disp_en = 0;
    m_lv[s] = 1; m_lr[s] = 0;
    m_ln[s] = !m_fv[lp] || !m_cv[m_fs[lp]];
    m_lt[s] = m_ln[s] ? 0 : m_cq[m_fs[lp]];
  endtask

  function automatic bit differs(input int i);
    return (m_cv[i] != m_kv[i]) || (m_cv[i] && m_cq[i] != m_kq[i]);
  endfunction

  task automatic repair();
    int n = 0, cnt = 0, expc;
    for (int i = 0; i < ST_N; i++) if (differs(i)) n++;
    expc = (n == 0) ? 1 : n;
    repair_start = 1; @(negedge clk); repair_start = 0;
    while (walk_busy && cnt < 64) begin
      iss_en = 1; iss_slot = 0;
      st_wr_en = 1; st_wr_pc = 4'd3; st_wr_valid = 1; st_wr_sqi = 5'd9;
      #1 chk(!iss_valid, "R8 issue during walk", int'(iss_valid), 0);
      @(negedge clk); cnt++;
    end
    iss_en = 0; st_wr_en = 0;
    chk(cnt == expc, "R4 walk length", cnt, expc);
    for (int s = 0; s < LQ_N; s++) begin
      if (m_lv[s] && !m_ln[s]) begin
        for (int i = 0; i < ST_N; i++) begin
          if (differs(i) && m_kv[i] && m_kq[i] == m_lt[s]) begin
            m_lt[s] = m_cq[i]; m_ln[s] = !m_cv[i]; m_lr[s] = 1;
            break;
          end
        end
      end
    end
    for (int i = 0; i < ST_N; i++) begin m_kv[i] = m_cv[i]; m_kq[i] = m_cq[i]; end
  endtask

  task automatic issue_chk(input int s, input string req);
    iss_en = 1; iss_slot = 3'(s);
    #1;
    chk(iss_valid == m_lv[s], {req, " issue valid"}, int'(iss_valid), int'(m_lv[s]));
    if (m_lv[s] && iss_valid) begin
      chk(iss_null == m_ln[s], {req, " null tag"}, int'(iss_null), int'(m_ln[s]));
      if (!m_ln[s]) chk(iss_tag == 5'(m_lt[s]), {req, " tag"}, int'(iss_tag), m_lt[s]);
      chk(iss_redisp == m_lr[s], {req, " redispatch flag"}, int'(iss_redisp), int'(m_lr[s]));
    end
    @(negedge clk); iss_en = 0;
    m_lv[s] = 0; m_lr[s] = 0;
    #1 chk(redisp_mask[s] == 1'b0, "R10 flag cleared by issue", int'(redisp_mask[s]), 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int seed_v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(walk_busy == 0, "R1 busy after reset", int'(walk_busy), 0);
    chk(redisp_mask == '0, "R1 flags after reset", int'(redisp_mask), 0);
    iss_en = 1; iss_slot = 0; #1;
    chk(iss_valid == 0, "R1 nothing pending", int'(iss_valid), 0);
    @(negedge clk); iss_en = 0;

    // chained move, removal, unchanged, null cases
    wr_store(1, 1, 3); wr_store(2, 1, 5); wr_store(4, 1, 12); wr_store(6, 1, 20);
    wr_fp(1, 1, 1); wr_fp(2, 1, 2); wr_fp(4, 1, 9); wr_fp(5, 1, 4);
    wr_fp(6, 1, 6); wr_fp(7, 1, 3);
    dispatch(0, 1); dispatch(1, 2); dispatch(2, 3); dispatch(3, 4);
    dispatch(4, 5); dispatch(5, 6);
    take_ckpt();
    wr_store(1, 1, 5); wr_store(2, 1, 7); wr_store(6, 0, 0);
    repair();
    #1 chk(redisp_mask == 8'b0010_0011, "R5 flags after repair", int'(redisp_mask), 8'h23);
    issue_chk(0, "R6 chain first move only");
    issue_chk(1, "R5 moved slot");
    issue_chk(2, "R3 no prediction");
    issue_chk(3, "R3 invalid store");
    issue_chk(4, "R7 unchanged entry");
    issue_chk(5, "R5 removed store");
    dispatch(6, 7);
    issue_chk(6, "R9 write during walk dropped");
    dispatch(0, 5);
    issue_chk(0, "R2 plain lookup");
    take_ckpt();
    repair();

    for (int ep = 0; ep < 40; ep++) begin
      for (int k = 0; k < 6; k++)
        wr_store($urandom_range(0, 15), ($urandom_range(0, 4) != 0), $urandom_range(0, 7));
      for (int k = 0; k < 4; k++)
        wr_fp($urandom_range(0, 15), ($urandom_range(0, 5) != 0), $urandom_range(0, 15));
      for (int s = 0; s < LQ_N; s++) dispatch(s, $urandom_range(0, 15));
      take_ckpt();
      seed_v = $urandom_range(0, 4);
      for (int k = 0; k < seed_v; k++)
        wr_store($urandom_range(0, 15), ($urandom_range(0, 3) != 0), $urandom_range(0, 7));
      repair();
      for (int s = 0; s < LQ_N; s++) issue_chk(s, "R2 R5 random episode");
    end
    finish_run();
  end
endmodule